// File: doc/BRIEF.md
# Configuration Store with One-Way Read/Write Lock

This block holds the personality of a small programmable sum-of-products logic array. It has one word of connection bits for each product term and a separate word with a four-bit configuration field for each output macrocell. The whole store is driven out on flat ports so that the array and macrocell logic can use it directly.

A command stream carries four operations:
- erase everything;
- program one word;
- read one word back;
- engage the security lock.

Read results leave on a response stream. A one-cycle error pulse flags any command that the block refuses.

Programming can only move a cell away from its erased value, so changing a pattern means erasing first. Once the lock is engaged, all readback and all programming are refused. Only a full erase releases the lock. A reset returns the store to the blank, unlocked state.

Stream rules: a command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high. The response slot is one entry deep. `cmd_ready` is low only while a response is waiting and `rsp_ready` is low. A waiting response holds `rsp_valid` high and keeps `rsp_data` constant until it is taken. The slot drains on the same edge that accepts the next command.

Top module: `cfgmem_ctrl`

## Requirements
- R1: After reset the outputs are as follows: `cmd_ready`=1, `rsp_valid`=0, `err`=0, `locked`=0, every array bit 0 (open), every configuration bit 1.
- R2: An erase command (`cmd_op`=2'b00) clears every array bit to 0, sets every configuration bit to 1 and clears the lock. It is accepted even while locked, and the new state is visible after the accepting edge.
- R3: A program command (`cmd_op`=2'b01) to a term address (0 to TERM_ROWS-1) ORs `cmd_data` into that word. A bit that is already 1 is never returned to 0 by programming.
- R4: A program command to address TERM_ROWS (the configuration word) ANDs the low CELLS*CELL_CFG_W bits of `cmd_data` into the configuration bits. Macrocell k owns bits [4k+3:4k], and a configuration bit never rises without an erase.
- R5: A verify command (`cmd_op`=2'b10) to a valid address while unlocked presents a response after the accepting edge. The response is the stored word, and for the configuration word it is zero-extended.
- R6: A set-lock command (`cmd_op`=2'b11) raises `locked` after the accepting edge. The lock stays high through any later command except an erase.
- R7: A program command while locked is refused. `err` is high for exactly the one cycle after the accepting edge, and no stored bit changes.
- R8: A verify command while locked is refused. `err` pulses for one cycle and no response is produced.
- R9: A program or verify command to an address above TERM_ROWS is refused with a one-cycle `err` pulse. It causes no change to the store and produces no response.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `cmd_ready` is 0 and `rsp_data` stays constant. When `rsp_ready` is high, a pending response drains on the same edge that accepts the next command.
- R11: Erase and set-lock commands never raise `err` and never produce a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset to the blank, unlocked state |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command slot can accept |
| cmd_op | input | 2 | 00 erase, 01 program, 10 verify, 11 set lock |
| cmd_addr | input | ADDR_W (7) | Term word index, or TERM_ROWS for the configuration word |
| cmd_data | input | WORD_W (36) | Program data |
| rsp_valid | output | 1 | Read result waiting |
| rsp_ready | input | 1 | Consumer takes the read result |
| rsp_data | output | WORD_W (36) | Read result |
| err | output | 1 | One-cycle pulse for a refused command |
| locked | output | 1 | Security lock state |
| array_bits | output | TERM_ROWS*WORD_W (2664) | Term connection bits; term t at [t*WORD_W +: WORD_W] |
| cfg_bits | output | CELLS*CELL_CFG_W (32) | Macrocell configuration bits |

## Verification
Two functions can land on one clock edge: the draining of a held read result and the acceptance of the next command, which may itself be a read. The bench provokes this by holding `rsp_ready` low with a second read queued behind a pending result. It then checks that `cmd_ready` stays low and the held data does not move. After that it raises `rsp_ready` and checks that, one edge later, the slot carries the second word rather than the first. The lock gives the other such case: a refused program offered in the cycle right after the lock engages must not leave a mark on the store.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
  typedef enum logic [1:0] {
    OP_ERASE  = 2'b00,
    OP_PROG   = 2'b01,
    OP_VERIFY = 2'b10,
    OP_LOCK   = 2'b11
  } cmd_op_e;
endpackage

// File: rtl/cfgmem_store.sv
module cfgmem_store #(
  parameter int WORD_W    = 36,
  parameter int TERM_ROWS = 74,
  parameter int CFG_W     = 32,
  parameter int ADDR_W    = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        erase,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [WORD_W-1:0]           wr_data,
  output logic [WORD_W-1:0]           rd_data,
  output logic [TERM_ROWS*WORD_W-1:0] rows_flat,
  output logic [CFG_W-1:0]            cfg
);
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(TERM_ROWS);

  logic [WORD_W-1:0] rows_q [TERM_ROWS];

  generate
    for (genvar r = 0; r < TERM_ROWS; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          rows_q[r] <= '0;
        else if (erase)
          rows_q[r] <= '0;
        else if (wr_en && addr == ADDR_W'(r))
          rows_q[r] <= rows_q[r] | wr_data;
      end
      assign rows_flat[r*WORD_W +: WORD_W] = rows_q[r];

      // R3: without an erase, a closed cell stays closed
      assert_term_only_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !erase |=> ((rows_q[r] & $past(rows_q[r])) == $past(rows_q[r])));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg <= '1;
    else if (erase)
      cfg <= '1;
    else if (wr_en && addr == CFG_ADDR)
      cfg <= cfg & wr_data[CFG_W-1:0];
  end

  always_comb begin
    rd_data = '0;
    if (addr == CFG_ADDR) rd_data[CFG_W-1:0] = cfg;
    for (int r = 0; r < TERM_ROWS; r++)
      if (addr == ADDR_W'(r)) rd_data = rows_q[r];
  end

  // R4: configuration bits fall only through programming
  assert_cfg_only_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !erase |=> ((cfg | $past(cfg)) == $past(cfg)));
  // R2: erase restores the blank configuration word
  assert_erase_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (cfg == '1));
endmodule

// File: rtl/cfgmem_lock.sv
module cfgmem_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic erase,
  input  logic engage,
  output logic locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      locked <= 1'b0;
    else if (erase)  locked <= 1'b0;
    else if (engage) locked <= 1'b1;
  end

  // R6: the lock is released by nothing but an erase
  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !erase) |=> locked);
  // R2: erase always opens the lock
  assert_erase_unlocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> !locked);
endmodule

// File: rtl/cfgmem_rsp.sv
module cfgmem_rsp #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10: a stalled result keeps its value
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/cfgmem_ctrl.sv
module cfgmem_ctrl #(
  parameter int WORD_W     = 36,
  parameter int TERM_ROWS  = 74,
  parameter int CELLS      = 8,
  parameter int CELL_CFG_W = 4,
  parameter int ADDR_W     = $clog2(TERM_ROWS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [1:0]                  cmd_op,
  input  logic [ADDR_W-1:0]           cmd_addr,
  input  logic [WORD_W-1:0]           cmd_data,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic [WORD_W-1:0]           rsp_data,
  output logic                        err,
  output logic                        locked,
  output logic [TERM_ROWS*WORD_W-1:0] array_bits,
  output logic [CELLS*CELL_CFG_W-1:0] cfg_bits
);
  import cfgmem_pkg::*;

  localparam int CFG_W = CELLS * CELL_CFG_W;

  cmd_op_e           op;
  logic              fire, addr_ok, is_access;
  logic              do_erase, do_lock, do_prog, do_read, refuse;
  logic [WORD_W-1:0] rd_word;

  assign op        = cmd_op_e'(cmd_op);
  assign fire      = cmd_valid && cmd_ready;
  assign addr_ok   = cmd_addr <= ADDR_W'(TERM_ROWS);
  assign is_access = (op == OP_PROG) || (op == OP_VERIFY);
  assign do_erase  = fire && op == OP_ERASE;
  assign do_lock   = fire && op == OP_LOCK;
  assign do_prog   = fire && op == OP_PROG   && !locked && addr_ok;
  assign do_read   = fire && op == OP_VERIFY && !locked && addr_ok;
  assign refuse    = fire && is_access && (locked || !addr_ok);

  cfgmem_store #(.WORD_W(WORD_W), .TERM_ROWS(TERM_ROWS), .CFG_W(CFG_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .erase(do_erase), .wr_en(do_prog), .addr(cmd_addr),
    .wr_data(cmd_data), .rd_data(rd_word), .rows_flat(array_bits), .cfg(cfg_bits));

  cfgmem_lock u_lock (
    .clk(clk), .rst_n(rst_n), .erase(do_erase), .engage(do_lock), .locked(locked));

  cfgmem_rsp #(.WORD_W(WORD_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .load(do_read), .load_data(rd_word), .out_ready(rsp_ready),
    .out_valid(rsp_valid), .out_data(rsp_data), .slot_free(cmd_ready));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= refuse;
  end

  // R7: a program while locked is flagged and leaves the configuration word alone
  assert_locked_prog_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_PROG && locked) |=> (err && $stable(cfg_bits)));
  // R8: a read while locked yields no result
  assert_locked_read_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_VERIFY && locked) |=> (err && !rsp_valid));
  // R11: erase and lock never flag an error
  assert_admin_no_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (op == OP_ERASE || op == OP_LOCK)) |=> !err);
  // R5: an accepted read produces a result
  assert_read_responds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_VERIFY && !locked && addr_ok) |=> rsp_valid);
endmodule

// File: tb/cfgmem_ctrl_test.sv
module cfgmem_ctrl_test;
  localparam int W = 36, ROWS = 74, AW = 7, CFGW = 32;

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [W-1:0]  data;
    logic          e_err;
    logic          e_rsp;
    logic [W-1:0]  e_data;
    logic          e_lock;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 7'd0,   36'h5,           1'b0, 1'b0, 36'h0,           1'b0}, // R3
    '{2'b01, 7'd0,   36'hA,           1'b0, 1'b0, 36'h0,           1'b0}, // R3
    '{2'b10, 7'd0,   36'h0,           1'b0, 1'b1, 36'hF,           1'b0}, // R3 R5
    '{2'b01, 7'd73,  36'h8_0000_0001, 1'b0, 1'b0, 36'h0,           1'b0}, // R3
    '{2'b10, 7'd73,  36'h0,           1'b0, 1'b1, 36'h8_0000_0001, 1'b0}, // R5
    '{2'b01, 7'd74,  36'h0_FFFF_FF0F, 1'b0, 1'b0, 36'h0,           1'b0}, // R4
    '{2'b01, 7'd74,  36'hF_FFFF_FFF6, 1'b0, 1'b0, 36'h0,           1'b0}, // R4
    '{2'b10, 7'd74,  36'h0,           1'b0, 1'b1, 36'h0_FFFF_FF06, 1'b0}, // R4 R5
    '{2'b10, 7'd75,  36'h0,           1'b1, 1'b0, 36'h0,           1'b0}, // R9
    '{2'b01, 7'd100, 36'hF_FFFF_FFFF, 1'b1, 1'b0, 36'h0,           1'b0}, // R9
    '{2'b11, 7'd0,   36'h0,           1'b0, 1'b0, 36'h0,           1'b1}, // R6 R11
    '{2'b01, 7'd0,   36'h30,          1'b1, 1'b0, 36'h0,           1'b1}, // R7
    '{2'b10, 7'd0,   36'h0,           1'b1, 1'b0, 36'h0,           1'b1}, // R8
    '{2'b00, 7'd0,   36'h0,           1'b0, 1'b0, 36'h0,           1'b0}, // R2 R11
    '{2'b10, 7'd0,   36'h0,           1'b0, 1'b1, 36'h0,           1'b0}, // R2
    '{2'b10, 7'd74,  36'h0,           1'b0, 1'b1, 36'h0_FFFF_FFFF, 1'b0}  // R2
  };

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, rsp_ready = 1;
  logic [1:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [W-1:0] cmd_data = 0;
  logic cmd_ready, rsp_valid, err, locked;
  logic [W-1:0] rsp_data;
  logic [ROWS*W-1:0] array_bits;
  logic [CFGW-1:0] cfg_bits;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cfgmem_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .err(err), .locked(locked), .array_bits(array_bits), .cfg_bits(cfg_bits));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge accept, sample at the next falling edge
  task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [W-1:0] d);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cmd_ready", 64'(cmd_ready), 64'd1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 err", 64'(err), 64'd0);
    chk("R1 locked", 64'(locked), 64'd0);
    chk("R1 array open", 64'(array_bits == '0), 64'd1);
    chk("R1 cfg blank", 64'(cfg_bits), 64'hFFFF_FFFF);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].op, VECS[i].addr, VECS[i].data);
      chk($sformatf("vec%0d err (R7 R8 R9 R11)", i), 64'(err), 64'(VECS[i].e_err));
      chk($sformatf("vec%0d rsp_valid (R5 R8)", i), 64'(rsp_valid), 64'(VECS[i].e_rsp));
      if (VECS[i].e_rsp) chk($sformatf("vec%0d rsp_data (R3 R4 R5)", i), 64'(rsp_data), 64'(VECS[i].e_data));
      chk($sformatf("vec%0d locked (R2 R6)", i), 64'(locked), 64'(VECS[i].e_lock));
      if (i == 7) chk("R4 cfg port", 64'(cfg_bits), 64'hFFFF_FF06);
      if (i == 12) chk("R7 term0 untouched", 64'(array_bits[0 +: W]), 64'hF);
    end
    @(negedge clk);
    chk("R7 err single pulse", 64'(err), 64'd0);
    chk("R2 array open after erase", 64'(array_bits == '0), 64'd1);

    // R10: stalled result, queued read, simultaneous drain and accept
    send(2'b01, 7'd0, 36'h3C);
    rsp_ready = 0;
    send(2'b10, 7'd0, 36'h0);
    chk("R10 result present", 64'(rsp_valid), 64'd1);
    chk("R10 not ready", 64'(cmd_ready), 64'd0);
    cmd_valid = 1; cmd_op = 2'b10; cmd_addr = 7'd74; cmd_data = '0;
    @(posedge clk); @(negedge clk);
    chk("R10 still not ready", 64'(cmd_ready), 64'd0);
    chk("R10 data held", 64'(rsp_data), 64'h3C);
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
    chk("R10 second result valid", 64'(rsp_valid), 64'd1);
    chk("R10 second result data", 64'(rsp_data), 64'hF_FFFF_FFFF & 64'hFFFF_FFFF);
    @(posedge clk); @(negedge clk);
    chk("R10 drained", 64'(rsp_valid), 64'd0);

    // R6: lock right after programming, then a refused program on the next cycle
    send(2'b01, 7'd5, 36'h1);
    send(2'b11, 7'd0, 36'h0);
    send(2'b01, 7'd5, 36'hF0);
    chk("R7 refused after lock", 64'(err), 64'd1);
    chk("R7 term5 unchanged", 64'(array_bits[5*W +: W]), 64'h1);
    send(2'b01, 7'd74, 36'h0);
    chk("R7 cfg unchanged", 64'(cfg_bits), 64'hFFFF_FFFF);
    send(2'b11, 7'd0, 36'h0);
    chk("R6 lock stays", 64'(locked), 64'd1);
    send(2'b00, 7'd0, 36'h0);
    chk("R2 erase unlocks", 64'(locked), 64'd0);
    chk("R2 term5 opened", 64'(array_bits[5*W +: W]), 64'h0);
    chk("R11 erase no err", 64'(err), 64'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule